// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This peripheral holds a set of identical 32-bit timer channels behind a small memory-mapped register bus. Each channel counts down one step per clock from a value that software loads. When it reaches zero it reloads, adds one to a wrap counter that sits beside it, and raises its interrupt status. Counting needs two enables: one block-wide enable and each channel's own enable. So software can stop every channel at once, or stop a single channel without touching the others.

Software programs the reload value while a channel is stopped. Setting the channel enable then loads the counter and clears its wrap count. With a full-range reload, software gets elapsed ticks by inverting the current count. Each channel drives its own interrupt line, which is the status bit qualified by a mask bit. Status is cleared by writing a one to a separate clear register. The whole block runs on one clock and has an active-low synchronous reset.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every register reads zero and every interrupt output is low. The exception is the revision register at 0x10, which reads the constant 0x00010203.
- R2: The bus is word addressed, and writes take effect at the clock edge where `bus_sel` and `bus_write` are high. The control word is at 0x00, with the block enable in bit 0. Channel n occupies a window starting at 0x20 + 0x20*n. Inside the window: +0x00 config (bit 0 = channel enable), +0x04 reload, +0x08 count (read-only), +0x0C wrap count (read-only), +0x10 status (bit 0, read-only), +0x14 clear (reads 0), +0x18 mask (bit 0). Every other offset, and any read while `bus_sel` is low, returns zero.
- R3: A channel's count drops by exactly one per clock while both the block enable and the channel enable are set. It does not change while the block enable is clear.
- R4: A write that takes the channel enable from 0 to 1 loads the count from the reload register and zeroes the wrap count at that edge, whether or not the block enable is set. Writing 1 while the enable is already 1 changes neither.
- R5: A counting channel whose count is zero loads the reload value on the next clock, increments its wrap count and sets status bit 0. The count therefore repeats every reload+1 clocks.
- R6: While a channel's enable is clear, its count and wrap count hold their values.
- R7: Writing clear with bit 0 set clears the status bit. Writing clear with bit 0 at zero leaves it unchanged. A wrap in the same cycle as a clear leaves the status set.
- R8: `irq[n]` is high exactly when channel n's status bit and mask bit are both 1. A mask of 0 keeps it low.
- R9: Channels are independent: writes to, and counting by, one channel never alter another channel's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 4 | One interrupt line per channel |

## Verification
The wrap count and status only change after a channel has run for an exact number of clocks. Seen from the bus, the clock where counting starts and stops depends on the register stage of the block enable. The stimulus therefore first loads the channel with the block enable off, so the loaded value can be read back while frozen. It then turns the block enable on and off a known number of clocks apart and freezes the channel again. It compares the frozen count and wrap count with a tick-by-tick model of that exact tick count. The single-step rate is checked with two reads on consecutive clocks of a channel with a large reload.

// File: rtl/gp_timer_pkg.sv
// Package: shared constants and the per-channel state record for the timer bank.
// Assumes word-aligned byte addresses and a 32-byte window per channel.
package gp_timer_pkg;

    localparam int unsigned DATA_W = 32;

    // Word index inside a channel window (byte offset / 4)
    localparam logic [2:0] W_CFG    = 3'd0;
    localparam logic [2:0] W_RELOAD = 3'd1;
    localparam logic [2:0] W_COUNT  = 3'd2;
    localparam logic [2:0] W_WRAPS  = 3'd3;
    localparam logic [2:0] W_STAT   = 3'd4;
    localparam logic [2:0] W_CLR    = 3'd5;
    localparam logic [2:0] W_MASK   = 3'd6;

    // Word index inside the top window
    localparam logic [2:0] W_CTRL   = 3'd0;
    localparam logic [2:0] W_REV    = 3'd4;

    localparam logic [DATA_W-1:0] REV_ID = 32'h0001_0203;

    typedef struct packed {
        logic              len;
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] wraps;
        logic              stat;
        logic              mask;
    } chan_state_t;

endpackage

// File: rtl/gp_timer_decode.sv
// Module: address decoder for the timer bank.
// Splits a byte address into a window selector and a word index. Window 0 is
// the top-level block; window k (1..NCH) is channel k-1. Assumes misaligned
// addresses and word index 7 of a channel window are unmapped.
module gp_timer_decode #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_ctrl,
    output logic              hit_rev,
    output logic [NCH-1:0]    ch_hit,
    output logic [2:0]        word
);
    import gp_timer_pkg::*;

    localparam int unsigned SLOT_W = ADDR_W - 5;

    logic              aligned;
    logic [SLOT_W-1:0] slot;

    // Split the address into its fields
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        slot    = addr[ADDR_W-1:5];
        word    = addr[4:2];
    end

    // Decode the top-level window
    always_comb begin
        hit_ctrl = aligned && (slot == '0) && (word == W_CTRL);
        hit_rev  = aligned && (slot == '0) && (word == W_REV);
    end

    // One window match per channel
    for (genvar i = 0; i < NCH; i++) begin : hit_g
        assign ch_hit[i] = aligned && (slot == SLOT_W'(i + 1)) && (word != 3'd7);
    end

endmodule

// File: rtl/gp_timer_chan.sv
// Module: one down-counting timer channel with wrap counter and interrupt.
// Counts when run_gate (block enable) and its own enable are both set. A
// 0-to-1 enable write loads the reload value and zeroes the wrap count.
// Assumes wr_en is already qualified by select, write and window hit.
module gp_timer_chan #(
    parameter int unsigned DW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_gate,
    input  logic                      wr_en,
    input  logic [2:0]                word,
    input  logic [DW-1:0]             wdata,
    output gp_timer_pkg::chan_state_t st,
    output logic                      irq
);
    import gp_timer_pkg::*;

    logic          len_q, stat_q, mask_q;
    logic [DW-1:0] reload_q, cnt_q, wraps_q;
    logic          start, tick, wrap, clr_hit;

    // Derive the per-cycle events
    always_comb begin
        start   = wr_en && (word == W_CFG) && wdata[0] && !len_q;
        tick    = run_gate && len_q;
        wrap    = tick && (cnt_q == '0);
        clr_hit = wr_en && (word == W_CLR) && wdata[0];
    end

    // Software-written configuration bits and reload value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= 1'b0;
            mask_q   <= 1'b0;
            reload_q <= '0;
        end else if (wr_en) begin
            if (word == W_CFG)    len_q    <= wdata[0];
            if (word == W_MASK)   mask_q   <= wdata[0];
            if (word == W_RELOAD) reload_q <= wdata;
        end
    end

    // Down-counter: load on start, reload on wrap, otherwise step
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (start) cnt_q <= reload_q;
        else if (wrap)  cnt_q <= reload_q;
        else if (tick)  cnt_q <= cnt_q - 1'b1;
    end

    // Wrap counter: zeroed on start, bumped on each wrap
    always_ff @(posedge clk) begin
        if (!rst_n)     wraps_q <= '0;
        else if (start) wraps_q <= '0;
        else if (wrap)  wraps_q <= wraps_q + 1'b1;
    end

    // Status bit: a wrap wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= 1'b0;
        else if (wrap)    stat_q <= 1'b1;
        else if (clr_hit) stat_q <= 1'b0;
    end

    // Export state for read-back and the masked interrupt
    always_comb begin
        st.len    = len_q;
        st.reload = reload_q;
        st.cnt    = cnt_q;
        st.wraps  = wraps_q;
        st.stat   = stat_q;
        st.mask   = mask_q;
        irq       = stat_q & mask_q;
    end

endmodule

// File: rtl/gp_timer_bank.sv
// Module: top of the timer bank. Holds the block enable, decodes the bus,
// instantiates NCH channels and multiplexes read data. Reads are
// combinational from the address; writes commit on the rising clock edge.
module gp_timer_bank #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    irq
);
    import gp_timer_pkg::*;

    logic                     hit_ctrl, hit_rev;
    logic [NCH-1:0]           ch_hit;
    logic [2:0]               word;
    logic                     gen_q;
    logic                     wr_any;
    chan_state_t [NCH-1:0]    ch_st;

    gp_timer_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) dec_i (
        .addr     (bus_addr),
        .hit_ctrl (hit_ctrl),
        .hit_rev  (hit_rev),
        .ch_hit   (ch_hit),
        .word     (word)
    );

    // Qualify a write strobe for this cycle
    assign wr_any = bus_sel && bus_write;

    // Block enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                    gen_q <= 1'b0;
        else if (wr_any && hit_ctrl)   gen_q <= bus_wdata[0];
    end

    for (genvar i = 0; i < NCH; i++) begin : chan_g
        gp_timer_chan #(.DW(DATA_W)) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_gate (gen_q),
            .wr_en    (wr_any && ch_hit[i]),
            .word     (word),
            .wdata    (bus_wdata),
            .st       (ch_st[i]),
            .irq      (irq[i])
        );
    end

    // Read multiplexer: zero for unselected or unmapped accesses
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (hit_ctrl) bus_rdata = {31'd0, gen_q};
            if (hit_rev)  bus_rdata = REV_ID;
            for (int i = 0; i < NCH; i++) begin
                if (ch_hit[i]) begin
                    case (word)
                        W_CFG:    bus_rdata = {31'd0, ch_st[i].len};
                        W_RELOAD: bus_rdata = ch_st[i].reload;
                        W_COUNT:  bus_rdata = ch_st[i].cnt;
                        W_WRAPS:  bus_rdata = ch_st[i].wraps;
                        W_STAT:   bus_rdata = {31'd0, ch_st[i].stat};
                        W_MASK:   bus_rdata = {31'd0, ch_st[i].mask};
                        default:  bus_rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/gp_timer_bank_chk.sv
// Module: property checker for the timer bank, bound to the top module.
// Observes the bus, the block enable and each channel's exported state.
module gp_timer_bank_chk #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned ADDR_W = 8
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               bus_sel,
    input logic                               bus_write,
    input logic [ADDR_W-1:0]                  bus_addr,
    input logic [31:0]                        bus_wdata,
    input logic [NCH-1:0]                     irq,
    input logic                               gen_q,
    input gp_timer_pkg::chan_state_t [NCH-1:0] ch_st
);
    for (genvar i = 0; i < NCH; i++) begin : chk_g
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(32 + 32 * i);

        logic start_w, clr_w;
        assign start_w = bus_sel && bus_write && (bus_addr == BASE) &&
                         bus_wdata[0] && !ch_st[i].len;
        assign clr_w   = bus_sel && bus_write && (bus_addr == BASE + 8'h14) &&
                         bus_wdata[0];

        assert_gen_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!gen_q && ch_st[i].len) |=> $stable(ch_st[i].cnt));

        assert_start_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
            start_w |=> (ch_st[i].cnt == $past(ch_st[i].reload)) && (ch_st[i].wraps == 0));

        assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_q && ch_st[i].len && ch_st[i].cnt == 0) |=>
                (ch_st[i].wraps == $past(ch_st[i].wraps) + 1) && ch_st[i].stat);

        assert_local_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_st[i].len |=> ($stable(ch_st[i].cnt) && $stable(ch_st[i].wraps)) || ch_st[i].len);

        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_w && !(gen_q && ch_st[i].len && ch_st[i].cnt == 0)) |=> !ch_st[i].stat);

        assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_st[i].mask |-> !irq[i]);
    end
endmodule

bind gp_timer_bank gp_timer_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .gen_q     (gen_q),
    .ch_st     (ch_st)
);

// File: tb/gp_timer_bank_tb_top.sv
// Directed bench for the timer bank: one task per scenario, each self-checking.
module gp_timer_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] CFG = 0, RELOAD = 1, COUNT = 2, WRAPS = 3,
                           STAT = 4, CLR = 5, MASK = 6;

    gp_timer_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] ch_addr(input int n, input logic [2:0] w);
        return 8'(32 + 32 * n + 4 * int'(w));
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Model of R3/R5: advance a running channel by t ticks
    task automatic model_run(input logic [31:0] rl, inout logic [31:0] c,
                             inout logic [31:0] o, input int t);
        for (int k = 0; k < t; k++) begin
            if (c == 0) begin c = rl; o = o + 1; end
            else c = c - 1;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1", "irq after reset", {28'd0, irq}, 32'd0);
        bus_rd(8'h00, d); check("R1", "ctrl reset", d, 0);
        bus_rd(8'h10, d); check("R1", "revision", d, 32'h0001_0203);
        for (int n = 0; n < 4; n++) begin
            for (int w = 0; w < 7; w++) begin
                bus_rd(ch_addr(n, 3'(w)), d);
                check("R1", $sformatf("ch%0d word%0d reset", n, w), d, 0);
            end
        end
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_rd(8'h04, d); check("R2", "unmapped 0x04", d, 0);
        bus_rd(8'h3C, d); check("R2", "unmapped 0x3C", d, 0);
        bus_rd(8'hA0, d); check("R2", "unmapped 0xA0", d, 0);
        bus_rd(8'h11, d); check("R2", "misaligned 0x11", d, 0);
    endtask

    task automatic t_load_frozen();
        logic [31:0] d;
        bus_wr(ch_addr(0, RELOAD), 32'd3);
        bus_rd(ch_addr(0, RELOAD), d); check("R2", "reload readback", d, 3);
        bus_wr(ch_addr(0, CFG), 32'd1);
        bus_rd(ch_addr(0, CFG), d);   check("R2", "cfg readback", d, 1);
        bus_rd(ch_addr(0, COUNT), d); check("R4", "load without block enable", d, 3);
        repeat (10) @(negedge clk);
        bus_rd(ch_addr(0, COUNT), d); check("R3", "frozen while block off", d, 3);
    endtask

    task automatic t_run_wrap();
        logic [31:0] d, c, o;
        c = 3; o = 0;
        bus_wr(8'h00, 32'd1);
        repeat (9) @(negedge clk);
        bus_wr(8'h00, 32'd0);
        model_run(32'd3, c, o, 11);
        bus_rd(ch_addr(0, COUNT), d); check("R5", "count after 11 ticks", d, c);
        bus_rd(ch_addr(0, WRAPS), d); check("R5", "wraps after 11 ticks", d, o);
        bus_rd(ch_addr(0, STAT), d);  check("R5", "status set by wrap", d, 1);
        check("R8", "irq masked off", {31'd0, irq[0]}, 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        bus_wr(ch_addr(0, MASK), 32'd1);
        #1 check("R8", "irq with mask on", {31'd0, irq[0]}, 1);
        check("R9", "other irqs low", {29'd0, irq[3:1]}, 0);
        bus_wr(ch_addr(0, CLR), 32'd0);
        bus_rd(ch_addr(0, STAT), d); check("R7", "clear with 0 ignored", d, 1);
        bus_rd(ch_addr(0, CLR), d);  check("R2", "clear reads zero", d, 0);
        bus_wr(ch_addr(0, CLR), 32'd1);
        bus_rd(ch_addr(0, STAT), d); check("R7", "status cleared", d, 0);
        check("R8", "irq after clear", {31'd0, irq[0]}, 0);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        bus_wr(ch_addr(0, CFG), 32'd1);
        bus_rd(ch_addr(0, COUNT), d); check("R4", "no reload when already on", d, 0);
        bus_rd(ch_addr(0, WRAPS), d); check("R4", "wraps kept when already on", d, 2);
        bus_wr(ch_addr(0, CFG), 32'd0);
        bus_wr(ch_addr(0, CFG), 32'd1);
        bus_rd(ch_addr(0, COUNT), d); check("R4", "reload on re-enable", d, 3);
        bus_rd(ch_addr(0, WRAPS), d); check("R4", "wraps zeroed on re-enable", d, 0);
    endtask

    task automatic t_step_freeze();
        logic [31:0] a, b;
        bus_wr(ch_addr(0, CFG), 32'd0);
        bus_wr(ch_addr(1, RELOAD), 32'd1000);
        bus_wr(ch_addr(1, CFG), 32'd1);
        bus_wr(8'h00, 32'd1);
        bus_rd(ch_addr(1, COUNT), a);
        bus_rd(ch_addr(1, COUNT), b);
        check("R3", "one step per clock", b, a - 1);
        bus_wr(ch_addr(1, CFG), 32'd0);
        bus_rd(ch_addr(1, COUNT), a);
        repeat (5) @(negedge clk);
        bus_rd(ch_addr(1, COUNT), b);
        check("R6", "count held with channel off", b, a);
        bus_rd(ch_addr(1, WRAPS), b); check("R6", "wraps held with channel off", b, 0);
        bus_rd(ch_addr(0, COUNT), b); check("R6", "ch0 held while off", b, 3);
        bus_rd(ch_addr(2, COUNT), b); check("R9", "ch2 untouched", b, 0);
        bus_rd(ch_addr(2, RELOAD), b); check("R9", "ch2 reload untouched", b, 0);
        check("R9", "ch2 irq low", {31'd0, irq[2]}, 0);
        bus_wr(8'h00, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unmapped();
        t_load_frozen();
        t_run_wrap();
        t_irq();
        t_restart();
        t_step_freeze();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule